// File: doc/BRIEF.md
# Asynchronous External Memory Bus Controller

This block converts internal read and write requests into asynchronous memory cycles on a 16-bit external data bus. Each bus transfer has three phases, and each phase is counted in system clock cycles. In the setup phase the address and chip select settle. In the access phase a single enable strobe is active. In the hold phase the address and any write data stay on the bus after the strobe ends. The three counts come from a configuration register. That register comes out of reset with the slowest timing: 4 setup cycles, 15 access cycles and 3 hold cycles.

A requester presents a request with an address, a direction and a width. A 16-bit request makes one transfer. A 32-bit request makes two consecutive transfers, and the lower half-word is transferred first. The requester is held off until the final hold phase has ended. A one-cycle response strobe then returns any read data. Only the default bank is served, so the block drives a single chip select.

Top module: `xmem_async_ctl`

## Requirements
- R1: While reset is applied and in the first cycle after it, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` is low, `req_ready` is high and `rsp_valid` is low. The timing register resets to 4 setup, 15 access and 3 hold cycles.
- R2: Every transfer begins with a setup phase of the programmed length. During setup `mem_cs_n` is low, `mem_addr` holds the transfer address, and both `mem_oe_n` and `mem_we_n` are high.
- R3: An access phase of the programmed length follows setup. During access exactly one strobe is low: `mem_oe_n` for reads (`req_write`=0) or `mem_we_n` for writes (`req_write`=1). The two strobes are never low together, and neither is low while `mem_cs_n` is high.
- R4: A hold phase of the programmed length follows access. During hold `mem_cs_n` stays low with both strobes high, and `mem_addr` and `mem_dq_out` keep their access-phase values.
- R5: A programmed count of zero in any phase lasts one cycle.
- R6: A pulse on `cfg_we` loads `cfg_setup`, `cfg_access` and `cfg_hold`. Requests accepted after that pulse use the new counts.
- R7: A 16-bit request (`req_wide`=0) makes one transfer at `req_addr`, which is a half-word address. For a read, `rsp_rdata[15:0]` is the bus value sampled in the last access cycle, and `rsp_rdata[31:16]` is zero.
- R8: A 32-bit request (`req_wide`=1) makes two back-to-back transfers with bit 0 of `req_addr` ignored. The first transfer goes to the even address (bit 0 = 0) and carries `req_wdata[15:0]`. The second goes to the next address (bit 0 = 1) and carries `req_wdata[31:16]`. A read returns {second half, first half}.
- R9: `req_ready` is low from the cycle after acceptance until the final hold phase has finished. `rsp_valid` is high for exactly one cycle, which is the first cycle in which `req_ready` is high again. The busy time is (setup+access+hold) cycles per transfer.
- R10: `mem_dq_oe` is high in every setup, access and hold cycle of a write and low throughout a read. `rsp_rdata` is zero after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the timing register |
| cfg_setup | input | 4 | Setup phase cycles (0 means 1) |
| cfg_access | input | 4 | Access phase cycles (0 means 1) |
| cfg_hold | input | 4 | Hold phase cycles (0 means 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit, 0 = 16-bit |
| req_addr | input | ADDR_W | Half-word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Read data |
| mem_addr | output | ADDR_W | External half-word address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 16 | Write data to the bus |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_in | input | 16 | Read data from the bus |

## Verification
A phase counter that is loaded wrongly or ends early shows up in the very next transfer as a phase of the wrong length. The bench counts setup, access and hold cycles at the pins for every transfer. A wrong half-word select shows up at once, either on `mem_addr` in the second transfer or as swapped halves in `rsp_rdata`. If the sequencer leaves the hold phase at the wrong moment, the busy window is the wrong length and `rsp_valid` comes early or late. Read data sampled outside the access phase picks up the bench's marker value.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    localparam int TMG_W = 4;
    localparam int BUS_W = 16;
    localparam int REQ_W = 2 * BUS_W;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACCESS,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [TMG_W-1:0] setup;
        logic [TMG_W-1:0] access;
        logic [TMG_W-1:0] hold;
    } timing_t;

    localparam timing_t TMG_RESET = '{
        setup:  TMG_W'(4),
        access: TMG_W'(15),
        hold:   TMG_W'(3)
    };

    // Down-counter preload: a phase of n cycles starts at n-1; zero acts as one.
    function automatic logic [TMG_W-1:0] preload(input logic [TMG_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

endpackage

// File: rtl/xmem_timing_regs.sv
module xmem_timing_regs
    import xmem_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  timing_t wr_val,
    output timing_t tmg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmg <= TMG_RESET;
        end else if (wr_en) begin
            tmg <= wr_val;
        end
    end

endmodule

// File: rtl/xmem_phase_seq.sv
module xmem_phase_seq
    import xmem_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    two_xfers,
    input  timing_t tmg_in,
    output phase_e  phase,
    output logic    upper,
    output logic    access_last,
    output logic    done
);

    logic [TMG_W-1:0] cnt;
    timing_t          tmg_q;
    logic             two_q;
    logic             cnt_end;

    assign cnt_end     = (cnt == '0);
    assign access_last = (phase == PH_ACCESS) && cnt_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            upper <= 1'b0;
            two_q <= 1'b0;
            tmg_q <= TMG_RESET;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SETUP;
                        cnt   <= preload(tmg_in.setup);
                        tmg_q <= tmg_in;
                        two_q <= two_xfers;
                        upper <= 1'b0;
                    end
                end
                PH_SETUP: begin
                    if (cnt_end) begin
                        phase <= PH_ACCESS;
                        cnt   <= preload(tmg_q.access);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_ACCESS: begin
                    if (cnt_end) begin
                        phase <= PH_HOLD;
                        cnt   <= preload(tmg_q.hold);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt_end) begin
                        if (two_q && !upper) begin
                            upper <= 1'b1;
                            phase <= PH_SETUP;
                            cnt   <= preload(tmg_q.setup);
                        end else begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xmem_async_ctl.sv
module xmem_async_ctl
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [TMG_W-1:0]  cfg_setup,
    input  logic [TMG_W-1:0]  cfg_access,
    input  logic [TMG_W-1:0]  cfg_hold,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [REQ_W-1:0]  req_wdata,
    output logic              rsp_valid,
    output logic [REQ_W-1:0]  rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [BUS_W-1:0]  mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [BUS_W-1:0]  mem_dq_in
);

    timing_t           tmg_cur;
    timing_t           tmg_wr;
    phase_e            phase;
    logic              upper;
    logic              access_last;
    logic              done;
    logic              accept;
    logic              wr_q;
    logic              wide_q;
    logic [ADDR_W-1:0] addr_q;
    logic [REQ_W-1:0]  wdata_q;
    logic [BUS_W-1:0]  rd_lo;
    logic [BUS_W-1:0]  rd_hi;

    assign tmg_wr = '{setup: cfg_setup, access: cfg_access, hold: cfg_hold};

    xmem_timing_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .wr_val (tmg_wr),
        .tmg    (tmg_cur)
    );

    xmem_phase_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .two_xfers   (req_wide),
        .tmg_in      (tmg_cur),
        .phase       (phase),
        .upper       (upper),
        .access_last (access_last),
        .done        (done)
    );

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            wide_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rd_lo   <= '0;
            rd_hi   <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            wide_q  <= req_wide;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            rd_lo   <= '0;
            rd_hi   <= '0;
        end else if (access_last && !wr_q) begin
            if (upper) begin
                rd_hi <= mem_dq_in;
            end else begin
                rd_lo <= mem_dq_in;
            end
        end
    end

    // Wide requests ignore address bit 0: lower half even, upper half odd.
    assign mem_addr   = wide_q ? {addr_q[ADDR_W-1:1], upper} : addr_q;
    assign mem_dq_out = upper ? wdata_q[REQ_W-1:BUS_W] : wdata_q[BUS_W-1:0];
    assign mem_cs_n   = (phase == PH_IDLE);
    assign mem_oe_n   = !((phase == PH_ACCESS) && !wr_q);
    assign mem_we_n   = !((phase == PH_ACCESS) && wr_q);
    assign mem_dq_oe  = wr_q && (phase != PH_IDLE);
    assign rsp_valid  = done;
    assign rsp_rdata  = {rd_hi, rd_lo};

endmodule

// File: rtl/xmem_async_ctl_chk.sv
module xmem_async_ctl_chk
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [BUS_W-1:0]  mem_dq_out,
    input logic              mem_dq_oe
);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n)); // R3

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n); // R3

    AST_ADDR_HELD_ACCESS: assert property (@(posedge clk) disable iff (rst)
        ((!mem_oe_n || !mem_we_n) && $past(!mem_oe_n || !mem_we_n)) |-> $stable(mem_addr)); // R4

    AST_ADDR_HELD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && mem_oe_n && mem_we_n && $past(!mem_oe_n || !mem_we_n)) |-> $stable(mem_addr)); // R4

    AST_WDATA_HELD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out)); // R4

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe); // R10

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |-> !req_ready); // R9

    AST_RSP_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $rose(mem_cs_n)); // R9

endmodule

bind xmem_async_ctl xmem_async_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/xmem_async_ctl_bench.sv
module xmem_async_ctl_bench;
    import xmem_pkg::*;

    localparam int AW = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [TMG_W-1:0]  cfg_setup = '0;
    logic [TMG_W-1:0]  cfg_access = '0;
    logic [TMG_W-1:0]  cfg_hold = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic              req_wide = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [REQ_W-1:0]  req_wdata = '0;
    logic              rsp_valid;
    logic [REQ_W-1:0]  rsp_rdata;
    logic [AW-1:0]     mem_addr;
    logic              mem_cs_n;
    logic              mem_oe_n;
    logic              mem_we_n;
    logic [BUS_W-1:0]  mem_dq_out;
    logic              mem_dq_oe;
    logic [BUS_W-1:0]  mem_dq_in;

    int errs = 0;
    int checks = 0;

    always #10 clk = ~clk;

    function automatic logic [BUS_W-1:0] pat(input logic [AW-1:0] a);
        return a[15:0] ^ 16'h5AA5;
    endfunction

    // Memory model: valid data only while output enable is low.
    assign mem_dq_in = mem_oe_n ? 16'hBAD0 : pat(mem_addr);

    xmem_async_ctl #(.ADDR_W(AW)) u_xmem_async_ctl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_setup(cfg_setup),
        .cfg_access(cfg_access), .cfg_hold(cfg_hold), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int s, input int a, input int h);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_setup = TMG_W'(s);
        cfg_access = TMG_W'(a);
        cfg_hold = TMG_W'(h);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_req(input bit wr, input bit wide, input logic [AW-1:0] addr,
                           input logic [31:0] wd, input int es, input int ea,
                           input int eh, input string tag);
        logic [AW-1:0] a0;
        logic [AW-1:0] a1;
        logic [31:0]   exp_rd;
        int ns[2];
        int na[2];
        int nh[2];
        int busy;
        int nx;
        bit bad_ready, bad_cs, bad_addr, bad_strobe, bad_dq;
        busy = 0;
        bad_ready = 0; bad_cs = 0; bad_addr = 0; bad_strobe = 0; bad_dq = 0;
        for (int t = 0; t < 2; t++) begin
            ns[t] = 0; na[t] = 0; nh[t] = 0;
        end
        nx = wide ? 2 : 1;
        a0 = wide ? {addr[AW-1:1], 1'b0} : addr;
        a1 = {addr[AW-1:1], 1'b1};
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wide = wide;
        req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && busy < 200) begin
            int k;
            k = (wide && mem_addr == a1) ? 1 : 0;
            busy++;
            if (req_ready) bad_ready = 1;
            if (mem_cs_n) bad_cs = 1;
            if (mem_addr != a0 && !(wide && mem_addr == a1)) bad_addr = 1;
            if (wr ? !mem_oe_n : !mem_we_n) bad_strobe = 1;
            if (mem_dq_oe != wr) bad_dq = 1;
            if (wr && mem_dq_out != (k == 1 ? wd[31:16] : wd[15:0])) bad_dq = 1;
            if (!(wr ? mem_we_n : mem_oe_n)) na[k]++;
            else if (na[k] == 0) ns[k]++;
            else nh[k]++;
            @(negedge clk);
        end
        chk(busy == nx * (es + ea + eh), {"R9 ", tag}, "busy cycles", busy, nx * (es + ea + eh));
        chk(!bad_ready, "R9", "req_ready high while busy", bad_ready, 0);
        chk(req_ready, "R9", "req_ready at response", req_ready, 1);
        chk(!bad_cs, "R2", "chip select high while busy", bad_cs, 0);
        for (int t = 0; t < nx; t++) begin
            chk(ns[t] == es, {"R2 ", tag}, "setup cycles", ns[t], es);
            chk(na[t] == ea, {"R3 ", tag}, "access cycles", na[t], ea);
            chk(nh[t] == eh, {"R4 ", tag}, "hold cycles", nh[t], eh);
        end
        chk(!bad_addr, wide ? "R8" : "R7", "unexpected bus address", bad_addr, 0);
        chk(!bad_strobe, "R3", "wrong strobe asserted", bad_strobe, 0);
        chk(!bad_dq, "R10", "data driver or write data", bad_dq, 0);
        if (wr) exp_rd = 32'h0;
        else if (wide) exp_rd = {pat(a1), pat(a0)};
        else exp_rd = {16'h0, pat(a0)};
        chk(rsp_rdata == exp_rd, wr ? "R10" : (wide ? "R8" : "R7"), "rsp_rdata", rsp_rdata, exp_rd);
        @(negedge clk);
        chk(!rsp_valid, "R9", "rsp_valid one cycle", rsp_valid, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n, "R1", "strobes in reset",
            {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n, "R1", "strobes after reset",
            {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(!mem_dq_oe, "R1", "mem_dq_oe after reset", mem_dq_oe, 0);
        chk(req_ready && !rsp_valid, "R1", "ready/valid after reset",
            {req_ready, rsp_valid}, 2'b10);
    endtask

    task automatic t_default_read();
        run_req(1'b0, 1'b0, 20'h00123, 32'h0, 4, 15, 3, "R1 R7");
    endtask

    task automatic t_wide_write();
        set_cfg(2, 3, 1);
        run_req(1'b1, 1'b1, 20'h00455, 32'hCAFE1234, 2, 3, 1, "R6 R8");
    endtask

    task automatic t_wide_read();
        set_cfg(1, 2, 2);
        run_req(1'b0, 1'b1, 20'h0A0B2, 32'h0, 1, 2, 2, "R6 R8");
    endtask

    task automatic t_zero_counts();
        set_cfg(0, 0, 0);
        run_req(1'b1, 1'b0, 20'h00007, 32'h0000BEEF, 1, 1, 1, "R5");
        run_req(1'b0, 1'b1, 20'h3F001, 32'h0, 1, 1, 1, "R5 R8");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_default_read();
        t_wide_write();
        t_wide_read();
        t_zero_counts();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule